// File: doc/BRIEF.md
# Satellite Tracking Channel Correlator

This block is one tracking channel of a satellite navigation receiver. Every clock it takes one complex sample from one of three frequency-band streams and cuts each 8-bit ADC word down to a 4-bit signed value. A carrier oscillator then rotates the sample to remove the residual carrier. The channel multiplies the rotated sample by five time-shifted copies of a locally generated 1023-chip Gold code and adds the five complex products over one code epoch.

At each epoch boundary the five I/Q sums are copied into dump registers, the accumulators restart from zero, and a ready flag goes high. Software reads the dumps through a small register port, runs its own frequency, delay and phase loops, and writes new oscillator increments back. Those increments only take effect at the next epoch boundary, so no integration ever mixes two settings.

Top module: `trk_channel`

## Requirements
- R1: Config bits [1:0] choose the source band: 0, 1 or 2 selects the byte lanes [7:0], [15:8] or [23:16] of both `adc_i` and `adc_q`.
- R2: Each selected 8-bit two's-complement word is shifted right arithmetically by config bits [4:2], and the result is saturated into the signed 4-bit range [-8, 7].
- R3: The top two bits of a 32-bit carrier phase accumulator, which adds the active carrier increment every clock, select a rotation of the sample (I,Q). Quadrant 0 gives (I,Q), 1 gives (Q,-I), 2 gives (-I,-Q) and 3 gives (-Q,I).
- R4: The code is the C/A-style Gold code of the PRN in config bits [13:9] (field value = PRN-1). A chip of 0 adds the rotated sample and a chip of 1 subtracts it, so with a constant input every tap's epoch sum is -S times the rotated sample, where S is the number of samples per chip.
- R5: A 32-bit code phase accumulator advances the chip on each carry. An epoch is 1023 chips, so with increment 2^31 the dumps arrive every 2046 clocks, and with increment 2^30 every 4092 clocks.
- R6: There are five taps, spaced by config bits [8:5] samples. Read address t (0..4) returns the I sum of tap t and address 8+t returns its Q sum, sign-extended to 32 bits, one clock after `rd_en`.
- R7: At the epoch boundary all ten sums are latched together and the accumulators restart. `dump_ready` rises and stays high until address 12 is read, and a new dump sets it again.
- R8: Writes to address 0 (carrier increment) and address 1 (code increment) are held pending. They become active only at an epoch boundary, or at once while the active code increment is zero.
- R9: After reset all dump registers read zero, `dump_ready` is low and both active increments are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_i | input | 24 | In-phase ADC words, one byte per band |
| adc_q | input | 24 | Quadrature ADC words, one byte per band |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0 carrier increment, 1 code increment, 2 config |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address of a dump register |
| rd_data | output | 32 | Registered read data |
| dump_ready | output | 1 | New dumps are waiting |

## Verification
The hardest state to reach from the ports is a carrier phase pinned at a known non-zero quadrant. The increments only change at epoch boundaries, so the stimulus runs exactly one epoch at a quarter-turn or an eighth-turn increment and then writes zero. Over 2046 clocks the phase then lands on a known quadrant, and the following epoch's dumps show that rotation. Constant inputs make every tap sum a closed-form multiple of the rotated sample, because the balanced code contributes exactly one net -1 per chip period.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int NUM_TAPS = 5;
  localparam int G_LEN    = 10;
  localparam int SP_W     = 4;
  localparam int PRN_W    = 5;

  typedef struct packed {
    logic [PRN_W-1:0] prn;
    logic [SP_W-1:0]  spacing;
    logic [2:0]       shift;
    logic [1:0]       band;
  } chan_cfg_t;

  // Second-register stage pair for each code number, {stage_a, stage_b}.
  function automatic logic [7:0] g2_taps(input logic [PRN_W-1:0] idx);
    case (idx)
      5'd0:  g2_taps = {4'd2, 4'd6};
      5'd1:  g2_taps = {4'd3, 4'd7};
      5'd2:  g2_taps = {4'd4, 4'd8};
      5'd3:  g2_taps = {4'd5, 4'd9};
      5'd4:  g2_taps = {4'd1, 4'd9};
      5'd5:  g2_taps = {4'd2, 4'd10};
      5'd6:  g2_taps = {4'd1, 4'd8};
      5'd7:  g2_taps = {4'd2, 4'd9};
      5'd8:  g2_taps = {4'd3, 4'd10};
      5'd9:  g2_taps = {4'd2, 4'd3};
      5'd10: g2_taps = {4'd3, 4'd4};
      5'd11: g2_taps = {4'd5, 4'd6};
      5'd12: g2_taps = {4'd6, 4'd7};
      5'd13: g2_taps = {4'd7, 4'd8};
      5'd14: g2_taps = {4'd8, 4'd9};
      5'd15: g2_taps = {4'd9, 4'd10};
      5'd16: g2_taps = {4'd1, 4'd4};
      5'd17: g2_taps = {4'd2, 4'd5};
      5'd18: g2_taps = {4'd3, 4'd6};
      5'd19: g2_taps = {4'd4, 4'd7};
      5'd20: g2_taps = {4'd5, 4'd8};
      5'd21: g2_taps = {4'd6, 4'd9};
      5'd22: g2_taps = {4'd1, 4'd3};
      5'd23: g2_taps = {4'd4, 4'd6};
      5'd24: g2_taps = {4'd5, 4'd7};
      5'd25: g2_taps = {4'd6, 4'd8};
      5'd26: g2_taps = {4'd7, 4'd9};
      5'd27: g2_taps = {4'd8, 4'd10};
      5'd28: g2_taps = {4'd1, 4'd6};
      5'd29: g2_taps = {4'd2, 4'd7};
      5'd30: g2_taps = {4'd3, 4'd8};
      default: g2_taps = {4'd4, 4'd9};
    endcase
  endfunction
endpackage

// File: rtl/trk_front.sv
module trk_front #(
  parameter int NUM_BANDS = 3,
  parameter int ADC_W     = 8,
  parameter int SMP_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_BANDS*ADC_W-1:0]   adc_i,
  input  logic [NUM_BANDS*ADC_W-1:0]   adc_q,
  input  logic [1:0]                   band,
  input  logic [2:0]                   shift,
  output logic signed [SMP_W-1:0]      s_i,
  output logic signed [SMP_W-1:0]      s_q
);
  localparam logic signed [ADC_W-1:0] SMAX = ADC_W'((1 << (SMP_W-1)) - 1);
  localparam logic signed [ADC_W-1:0] SMIN = -SMAX - ADC_W'(1);

  logic [ADC_W-1:0] sel_i, sel_q;

  always_comb begin
    sel_i = adc_i[ADC_W-1:0];
    sel_q = adc_q[ADC_W-1:0];
    for (int b = 1; b < NUM_BANDS; b++) begin
      if (int'(band) == b) begin
        sel_i = adc_i[b*ADC_W +: ADC_W];
        sel_q = adc_q[b*ADC_W +: ADC_W];
      end
    end
  end

  function automatic logic signed [SMP_W-1:0] reduce(input logic [ADC_W-1:0] x,
                                                       input logic [2:0] sh);
    logic signed [ADC_W-1:0] y;
    y = $signed(x) >>> sh;
    if (y > SMAX)      reduce = SMAX[SMP_W-1:0];
    else if (y < SMIN) reduce = SMIN[SMP_W-1:0];
    else               reduce = y[SMP_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      s_i <= '0;
      s_q <= '0;
    end else begin
      s_i <= reduce(sel_i, shift);
      s_q <= reduce(sel_q, shift);
    end
  end
endmodule

// File: rtl/trk_carrier.sv
module trk_carrier #(
  parameter int NCO_W = 32,
  parameter int SMP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    apply,
  input  logic [NCO_W-1:0]        incr_new,
  input  logic signed [SMP_W-1:0] s_i,
  input  logic signed [SMP_W-1:0] s_q,
  output logic signed [SMP_W:0]   m_i,
  output logic signed [SMP_W:0]   m_q
);
  localparam int MW = SMP_W + 1;

  logic [NCO_W-1:0]      incr_act, phase;
  logic signed [MW-1:0]  ei, eq, ni, nq;

  always_comb begin
    ei = MW'(s_i);
    eq = MW'(s_q);
    case (phase[NCO_W-1 -: 2])
      2'd0:    begin ni = ei;  nq = eq;  end
      2'd1:    begin ni = eq;  nq = -ei; end
      2'd2:    begin ni = -ei; nq = -eq; end
      default: begin ni = -eq; nq = ei;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      incr_act <= '0;
      phase    <= '0;
      m_i      <= '0;
      m_q      <= '0;
    end else begin
      if (apply) incr_act <= incr_new;
      phase <= phase + incr_act;
      m_i   <= ni;
      m_q   <= nq;
    end
  end

  // R8: carrier increment changes only when the code side allows it
  a_r8_carr_hold: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(incr_act));
endmodule

// File: rtl/trk_code.sv
module trk_code import trk_pkg::*; #(
  parameter int NCO_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCO_W-1:0]     incr_new,
  input  logic [PRN_W-1:0]     prn,
  input  logic [SP_W-1:0]      spacing,
  output logic [NUM_TAPS-1:0]  taps,
  output logic                 apply,
  output logic                 tick
);
  localparam int CODE_LEN = (1 << G_LEN) - 1;
  localparam int MAX_SP   = (1 << SP_W) - 1;
  localparam int DL_LEN   = (NUM_TAPS - 1) * MAX_SP + 1;
  localparam int IDX_W    = $clog2(DL_LEN);

  logic [NCO_W-1:0]  incr_act, code_ph;
  logic [NCO_W:0]    ph_sum;
  logic              ovf, epoch_end, chip;
  logic [G_LEN-1:0]  chip_cnt, g1, g2;
  logic [DL_LEN-1:0] dl;
  logic [7:0]        tp;

  always_comb begin
    ph_sum    = {1'b0, code_ph} + {1'b0, incr_act};
    ovf       = ph_sum[NCO_W];
    epoch_end = ovf && (chip_cnt == G_LEN'(CODE_LEN - 1));
    apply     = epoch_end || (incr_act == '0);
    tp        = g2_taps(prn);
    chip      = g1[G_LEN-1] ^ g2[4'(tp[7:4] - 4'd1)] ^ g2[4'(tp[3:0] - 4'd1)];
  end

  always_comb begin
    for (int k = 0; k < NUM_TAPS; k++) begin
      taps[k] = dl[IDX_W'(k * int'(spacing))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      incr_act <= '0;
      code_ph  <= '0;
      chip_cnt <= '0;
      g1       <= '1;
      g2       <= '1;
      dl       <= '0;
      tick     <= 1'b0;
    end else begin
      if (apply) incr_act <= incr_new;
      code_ph <= ph_sum[NCO_W-1:0];
      if (ovf) begin
        if (epoch_end) begin
          chip_cnt <= '0;
          g1       <= '1;
          g2       <= '1;
        end else begin
          chip_cnt <= chip_cnt + 1'b1;
          g1 <= {g1[G_LEN-2:0], g1[2] ^ g1[9]};
          g2 <= {g2[G_LEN-2:0], g2[1] ^ g2[2] ^ g2[5] ^ g2[7] ^ g2[8] ^ g2[9]};
        end
      end
      dl   <= {dl[DL_LEN-2:0], chip};
      tick <= epoch_end;
    end
  end

  // R5: chip counter never leaves one code period
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
    chip_cnt <= G_LEN'(CODE_LEN - 1));
  // R5: epoch boundary restarts the code generator
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    epoch_end |=> (chip_cnt == '0) && (g1 == '1) && (g2 == '1));
  // R8: code increment changes only at a boundary or while idle
  a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(incr_act));
endmodule

// File: rtl/trk_accum.sv
module trk_accum import trk_pkg::*; #(
  parameter int SMP_W = 4,
  parameter int ACC_W = 24
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic signed [SMP_W:0]              m_i,
  input  logic signed [SMP_W:0]              m_q,
  input  logic [NUM_TAPS-1:0]                taps,
  input  logic                               tick,
  input  logic                               clr,
  output logic [NUM_TAPS-1:0][ACC_W-1:0]     dump_i,
  output logic [NUM_TAPS-1:0][ACC_W-1:0]     dump_q,
  output logic                               ready
);
  logic signed [ACC_W-1:0] ext_i, ext_q;
  logic signed [ACC_W-1:0] acc_i [NUM_TAPS];
  logic signed [ACC_W-1:0] acc_q [NUM_TAPS];

  assign ext_i = ACC_W'(m_i);
  assign ext_q = ACC_W'(m_q);

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic signed [ACC_W-1:0] term_i, term_q;
    assign term_i = taps[k] ? -ext_i : ext_i;
    assign term_q = taps[k] ? -ext_q : ext_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_i[k]  <= '0;
        acc_q[k]  <= '0;
        dump_i[k] <= '0;
        dump_q[k] <= '0;
      end else if (tick) begin
        dump_i[k] <= acc_i[k] + term_i;
        dump_q[k] <= acc_q[k] + term_q;
        acc_i[k]  <= '0;
        acc_q[k]  <= '0;
      end else begin
        acc_i[k] <= acc_i[k] + term_i;
        acc_q[k] <= acc_q[k] + term_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       ready <= 1'b0;
    else if (tick) ready <= 1'b1;
    else if (clr)  ready <= 1'b0;
  end

  // R7: a dump always raises the flag
  a_r7_ready_set: assert property (@(posedge clk) disable iff (rst)
    tick |=> ready);
  // R7: dump registers only move at a boundary
  a_r7_dump_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dump_i) && $stable(dump_q));
  // R7: reading the last register drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !tick) |=> !ready);
  // R7: integration restarts from zero after a dump
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    tick |=> (acc_i[0] == '0) && (acc_q[NUM_TAPS-1] == '0));
endmodule

// File: rtl/trk_channel.sv
module trk_channel import trk_pkg::*; #(
  parameter int NUM_BANDS = 3,
  parameter int ADC_W     = 8,
  parameter int SMP_W     = 4,
  parameter int NCO_W     = 32,
  parameter int ACC_W     = 24,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANDS*ADC_W-1:0]  adc_i,
  input  logic [NUM_BANDS*ADC_W-1:0]  adc_q,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        dump_ready
);
  localparam int CFG_W = $bits(chan_cfg_t);
  localparam logic [ADDR_W-1:0] A_CARR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(8 + NUM_TAPS - 1);

  chan_cfg_t                     cfg;
  logic [NCO_W-1:0]              carr_pend, code_pend;
  logic signed [SMP_W-1:0]       s_i, s_q;
  logic signed [SMP_W:0]         m_i, m_q;
  logic [NUM_TAPS-1:0]           taps;
  logic                          apply, tick, clr;
  logic [NUM_TAPS-1:0][ACC_W-1:0] dump_i, dump_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '{prn: '0, spacing: SP_W'(1), shift: 3'd0, band: 2'd0};
      carr_pend <= '0;
      code_pend <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CARR:  carr_pend <= wr_data[NCO_W-1:0];
        A_CODE:  code_pend <= wr_data[NCO_W-1:0];
        A_CFG:   cfg       <= chan_cfg_t'(wr_data[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  trk_front #(.NUM_BANDS(NUM_BANDS), .ADC_W(ADC_W), .SMP_W(SMP_W)) u_front (
    .clk(clk), .rst(rst), .adc_i(adc_i), .adc_q(adc_q),
    .band(cfg.band), .shift(cfg.shift), .s_i(s_i), .s_q(s_q));

  trk_code #(.NCO_W(NCO_W)) u_code (
    .clk(clk), .rst(rst), .incr_new(code_pend), .prn(cfg.prn),
    .spacing(cfg.spacing), .taps(taps), .apply(apply), .tick(tick));

  trk_carrier #(.NCO_W(NCO_W), .SMP_W(SMP_W)) u_carrier (
    .clk(clk), .rst(rst), .apply(apply), .incr_new(carr_pend),
    .s_i(s_i), .s_q(s_q), .m_i(m_i), .m_q(m_q));

  trk_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst(rst), .m_i(m_i), .m_q(m_q), .taps(taps), .tick(tick),
    .clr(clr), .dump_i(dump_i), .dump_q(dump_q), .ready(dump_ready));

  assign clr = rd_en && (rd_addr == A_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      for (int t = 0; t < NUM_TAPS; t++) begin
        if (rd_addr == ADDR_W'(t))
          rd_data <= DATA_W'($signed(dump_i[t]));
        if (rd_addr == ADDR_W'(8 + t))
          rd_data <= DATA_W'($signed(dump_q[t]));
      end
    end
  end

  // R6: read data only changes on a read strobe
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_trk_channel.sv
module test_trk_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] adc_i = '0, adc_q = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dump_ready;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  trk_channel i_trk_channel (
    .clk(clk), .rst(rst), .adc_i(adc_i), .adc_q(adc_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .dump_ready(dump_ready));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = $signed(rd_data);
  endtask

  task automatic wait_dump(output int at);
    @(negedge clk);
    while (!dump_ready) @(negedge clk);
    at = cyc;
  endtask

  // wait for a dump and discard it (clears the flag)
  task automatic skip_dump(output int at);
    int v;
    wait_dump(at);
    rd(12, v);
  endtask

  task automatic read_check(input string req, input int ei, input int eq);
    int v;
    for (int t = 0; t < 5; t++) begin
      rd(t, v);     chk(req, v, ei);
      rd(8 + t, v); chk(req, v, eq);
    end
    chk("R7", int'(dump_ready), 0);
  endtask

  function automatic int red(input int x, input int sh);
    int y;
    y = x >>> sh;
    if (y > 7) y = 7;
    if (y < -8) y = -8;
    return y;
  endfunction

  function automatic logic [31:0] cfgw(input int band, input int sh, input int sp, input int prn);
    return 32'((prn << 9) | (sp << 5) | (sh << 2) | band);
  endfunction

  initial begin
    int t0, t1, t2;
    int vi, vq;
    adc_i = {8'd100, 8'd20, 8'd48};
    adc_q = {8'hFD, 8'h9C, 8'hB0};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9", int'(dump_ready), 0);
    read_check("R9", 0, 0);

    // band 0, shift 4, spacing 1, PRN 1, two samples per chip
    wr(2, cfgw(0, 4, 1, 0));
    wr(0, 32'd0);
    wr(1, 32'h8000_0000);
    skip_dump(t0);
    wait_dump(t1);
    vi = red(48, 4); vq = red(-80, 4);
    read_check("R4", -2 * vi, -2 * vq);
    wait_dump(t2);
    chk("R5", t2 - t1, 2046);
    read_check("R6", -2 * vi, -2 * vq);

    // R1/R2: band 1 with shift 2, Q saturates low
    wr(2, cfgw(1, 2, 1, 0));
    skip_dump(t0);
    wait_dump(t1);
    read_check("R2", -2 * red(20, 2), -2 * red(-100, 2));

    // R1/R2: band 2 with shift 0, I saturates high
    wr(2, cfgw(2, 0, 1, 0));
    skip_dump(t0);
    wait_dump(t1);
    read_check("R1", -2 * red(100, 0), -2 * red(-3, 0));

    // R4/R6: another code number and wider spacing
    wr(2, cfgw(0, 4, 3, 6));
    skip_dump(t0);
    wait_dump(t1);
    read_check("R4", -2 * vi, -2 * vq);

    // R8/R3: one epoch of quarter turns, then freeze at 180 degrees
    wr(0, 32'h4000_0000);
    wait_dump(t1);
    read_check("R8", -2 * vi, -2 * vq);
    wr(0, 32'd0);
    skip_dump(t0);
    wait_dump(t1);
    read_check("R3", 2 * vi, 2 * vq);

    // R3: one epoch of eighth turns moves phase to quadrant 1: (Q,-I)
    wr(0, 32'h2000_0000);
    wait_dump(t1);
    read_check("R3", 2 * vi, 2 * vq);
    wr(0, 32'd0);
    skip_dump(t0);
    wait_dump(t1);
    read_check("R3", -2 * vq, 2 * vi);

    // R8/R5: code rate change waits for the boundary
    wr(1, 32'h4000_0000);
    wait_dump(t2);
    chk("R8", t2 - t1, 2046);
    rd(12, vi);
    wait_dump(t0);
    chk("R5", t0 - t2, 4092);
    rd(12, vi);
    wait_dump(t1);
    chk("R5", t1 - t0, 4092);
    vi = red(48, 4);
    read_check("R4", -4 * vq, 4 * vi);

    // R7: flag stays up while unread across a further dump
    wait_dump(t1);
    repeat (4200) @(negedge clk);
    chk("R7", int'(dump_ready), 1);
    read_check("R7", -4 * vq, 4 * vi);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule